// File: doc/BRIEF.md
# Sleep Timer with Cross-Domain Compare

This block keeps a 24-bit count that advances on every rising edge of a slow (about 32 kHz) reference clock. The count starts as soon as the slow-domain reset is released and never stops or reloads. Software reaches the timer through a byte-wide register port on the fast system clock. A read of the low byte freezes the whole count into a holding register, so the middle and high bytes read afterwards belong to the same value. A copy of the count in Gray code crosses into the system domain, so a capture never catches bits from two different counts.

Software sets a 24-bit compare value in two steps. It writes the upper bytes into staging registers, then writes the low byte. The low-byte write sends the complete value to the slow domain through a toggle request/acknowledge handshake. A ready bit stays low until the acknowledge comes back. When the count equals the compare value on a slow edge, the block sets a sticky interrupt flag and sends a one-cycle wake/trigger pulse. The interrupt pin is the flag gated by an enable bit.

The register port has no back-pressure: every read or write strobe is taken in the cycle it is presented. Read data follows one cycle later and holds until the next read. Load pacing is the one flow rule, and software follows it by polling the ready bit.

Top module: `sleep_cmp_timer`

## Requirements
- R1: The slow-domain counter is 0 while its reset is asserted. After release it rises by exactly one on each slow rising edge and wraps modulo 2^24.
- R2: Address 0 is the low byte, 1 the middle byte and 2 the high byte. A read of address 0 returns bits 7:0 of the current count and captures all 24 bits. Reads of addresses 1 and 2 return bits 15:8 and 23:16 of the latest capture, even after the count has moved on. Read data appears on `reg_rdata` in the cycle after the strobe and holds until the next read.
- R3: Writes to addresses 2 and 1 stage the high and middle compare bytes. A write to address 0 while ready is 1 loads {staged high, staged middle, written byte} into the slow domain. Ready reads 0 from the next cycle and reads 1 again within four slow periods.
- R4: A write to address 0 while ready is 0 is ignored. It starts no load and leaves the value in transit unchanged.
- R5: A compare event happens on the slow edge at which the count equals the compare value. A newly loaded value is first compared at the fourth slow edge after the low-byte write. With C the count at the write, a value of C+3 or more (below the wrap) fires, and C, C+1 or C+2 do not. Software should keep a margin of 5.
- R6: Each event produces a `wake_pulse` exactly one system cycle wide. The flag becomes set at the third system edge after the slow edge that caused the event.
- R7: The flag is sticky. A write to address 3 with bit 1 = 0 clears it, and writing bit 1 = 1 has no effect on it.
- R8: If an event and a clear reach the flag in the same cycle, the flag ends set.
- R9: `irq` is high exactly when the flag and the enable bit (address 3, bit 0) are both 1.
- R10: After reset the compare value is 0xFFFFFF and the staged high and middle bytes are 0xFF. Ready is 1, the flag and enable are 0, `reg_rdata` is 0 and no event occurs.
- R11: Address 3 reads bit 0 enable, bit 1 flag, bit 2 ready and bit 3 the synchronized slow-clock level; bits 7:4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the register port |
| sys_rst_n | input | 1 | Active-low asynchronous reset, system domain |
| slow_clk | input | 1 | Slow reference clock that drives the counter |
| slow_rst_n | input | 1 | Active-low asynchronous reset, slow domain |
| reg_addr | input | 2 | Register select: 0 low, 1 middle, 2 high, 3 control/status |
| reg_rd | input | 1 | Read strobe, one system cycle |
| reg_wr | input | 1 | Write strobe, one system cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after a read strobe |
| irq | output | 1 | Interrupt request: flag AND enable |
| wake_pulse | output | 1 | One-cycle pulse per compare event |

## Verification
The bench sweeps the compare offset across the load-latency boundary. A design with one synchronizer stage too many or too few would move the hit/miss edge away from C+3. It reads the count over a byte carry with a slow edge between the low read and the upper reads, which exposes any upper byte taken from the live count rather than the capture. It moves a flag clear across the cycles around the flag-set cycle: a clear that wins over a simultaneous event shows a dropped flag exactly at the coincident offset. A second low-byte write while a load is in flight would fire early if it were accepted. An upper-byte staging reset of zero would fire on the first low-only load.

// File: rtl/sleep_tmr_pkg.sv
package sleep_tmr_pkg;

  // bit positions in the control/status byte that software writes
  localparam int CTL_IE   = 0;
  localparam int CTL_FLAG = 1;

  // read view of the control/status byte, bits 3..0
  typedef struct packed {
    logic slow_lvl;
    logic ld_ready;
    logic flag;
    logic irq_en;
  } ctl_view_t;

endpackage

// File: rtl/st_bit_sync.sv
module st_bit_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/st_slow_core.sv
module st_slow_core #(
  parameter int             CNT_W       = 24,
  parameter int             SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] RESET_CMP = '1
) (
  input  logic             slow_clk,
  input  logic             slow_rst_n,
  input  logic             load_req_tgl,
  input  logic [CNT_W-1:0] load_val,
  output logic             load_ack_tgl,
  output logic [CNT_W-1:0] cnt_gray,
  output logic [CNT_W-1:0] cnt_o,
  output logic             evt_tgl
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             req_s;
  logic             ack_q;
  logic             evt_q;

  st_bit_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk  (slow_clk),
    .rst_n(slow_rst_n),
    .d    (load_req_tgl),
    .q    (req_s)
  );

  assign cnt_nxt = cnt_q + CNT_W'(1);

  // free-running count plus a registered Gray copy of the same value
  always_ff @(posedge slow_clk or negedge slow_rst_n) begin
    if (!slow_rst_n) begin
      cnt_q    <= '0;
      cnt_gray <= '0;
    end else begin
      cnt_q    <= cnt_nxt;
      cnt_gray <= cnt_nxt ^ (cnt_nxt >> 1);
    end
  end

  // match detection, reported as a toggle for the crossing
  always_ff @(posedge slow_clk or negedge slow_rst_n) begin
    if (!slow_rst_n) begin
      evt_q <= 1'b0;
    end else if (cnt_q == cmp_q) begin
      evt_q <= ~evt_q;
    end
  end

  // load receiver: a new request level takes the value and echoes back
  always_ff @(posedge slow_clk or negedge slow_rst_n) begin
    if (!slow_rst_n) begin
      cmp_q <= RESET_CMP;
      ack_q <= 1'b0;
    end else if (req_s != ack_q) begin
      cmp_q <= load_val;
      ack_q <= req_s;
    end
  end

  assign load_ack_tgl = ack_q;
  assign evt_tgl      = evt_q;
  assign cnt_o        = cnt_q;

endmodule

// File: rtl/st_count_bridge.sv
module st_count_bridge #(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             sys_clk,
  input  logic             sys_rst_n,
  input  logic [CNT_W-1:0] gray_in,
  output logic [CNT_W-1:0] count_bin
);

  logic [CNT_W-1:0] gray_s;

  st_bit_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_gray_sync (
    .clk  (sys_clk),
    .rst_n(sys_rst_n),
    .d    (gray_in),
    .q    (gray_s)
  );

  // each binary bit is the parity of the Gray bits at and above it
  genvar g;
  generate
    for (g = 0; g < CNT_W; g++) begin : g_g2b
      assign count_bin[g] = ^gray_s[CNT_W-1:g];
    end
  endgenerate

endmodule

// File: rtl/st_cmp_loader.sv
module st_cmp_loader #(
  parameter int               CNT_W       = 24,
  parameter int               SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] RESET_CMP   = '1
) (
  input  logic             sys_clk,
  input  logic             sys_rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] value,
  input  logic             ack_tgl,
  output logic             req_tgl,
  output logic [CNT_W-1:0] staged,
  output logic             ld_ready
);

  logic ack_s;
  logic req_q;

  st_bit_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk  (sys_clk),
    .rst_n(sys_rst_n),
    .d    (ack_tgl),
    .q    (ack_s)
  );

  // idle whenever the returned level matches the request level
  assign ld_ready = (ack_s == req_q);

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      req_q  <= 1'b0;
      staged <= RESET_CMP;
    end else if (start && ld_ready) begin
      req_q  <= ~req_q;
      staged <= value;
    end
  end

  assign req_tgl = req_q;

endmodule

// File: rtl/sleep_cmp_timer.sv
module sleep_cmp_timer
  import sleep_tmr_pkg::*;
#(
  parameter int               CNT_W       = 24,
  parameter int               SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] RESET_CMP   = '1,
  localparam int              NBYTES      = CNT_W / 8,
  localparam int              ADDR_W      = $clog2(NBYTES + 1)
) (
  input  logic              sys_clk,
  input  logic              sys_rst_n,
  input  logic              slow_clk,
  input  logic              slow_rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq,
  output logic              wake_pulse
);

  localparam logic [ADDR_W-1:0] A_LOW = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(NBYTES);

  // crossing signals
  logic             req_tgl;
  logic             ack_tgl;
  logic [CNT_W-1:0] staged;
  logic [CNT_W-1:0] cnt_gray;
  logic [CNT_W-1:0] slow_cnt;
  logic             evt_tgl;

  // system-domain state
  logic [CNT_W-1:0] live_cnt;
  logic [CNT_W-1:0] snap_q;
  logic [CNT_W-1:8] stage_hi;
  logic [7:0]       rdata_q;
  logic             ld_ready;
  logic             ld_start;
  logic             slow_lvl;
  logic             evt_s;
  logic             evt_seen;
  logic             evt_hit;
  logic             flag_q;
  logic             flag_clr;
  logic             irq_en_q;
  logic             wake_q;
  logic             ctl_wr;
  ctl_view_t        ctl_view;

  st_slow_core #(
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES),
    .RESET_CMP  (RESET_CMP)
  ) u_core (
    .slow_clk    (slow_clk),
    .slow_rst_n  (slow_rst_n),
    .load_req_tgl(req_tgl),
    .load_val    (staged),
    .load_ack_tgl(ack_tgl),
    .cnt_gray    (cnt_gray),
    .cnt_o       (slow_cnt),
    .evt_tgl     (evt_tgl)
  );

  st_count_bridge #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_bridge (
    .sys_clk  (sys_clk),
    .sys_rst_n(sys_rst_n),
    .gray_in  (cnt_gray),
    .count_bin(live_cnt)
  );

  assign ld_start = reg_wr && (reg_addr == A_LOW);

  st_cmp_loader #(
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES),
    .RESET_CMP  (RESET_CMP)
  ) u_loader (
    .sys_clk  (sys_clk),
    .sys_rst_n(sys_rst_n),
    .start    (ld_start),
    .value    ({stage_hi, reg_wdata}),
    .ack_tgl  (ack_tgl),
    .req_tgl  (req_tgl),
    .staged   (staged),
    .ld_ready (ld_ready)
  );

  st_bit_sync #(.W(1), .STAGES(SYNC_STAGES)) u_lvl_sync (
    .clk  (sys_clk),
    .rst_n(sys_rst_n),
    .d    (slow_clk),
    .q    (slow_lvl)
  );

  st_bit_sync #(.W(1), .STAGES(SYNC_STAGES)) u_evt_sync (
    .clk  (sys_clk),
    .rst_n(sys_rst_n),
    .d    (evt_tgl),
    .q    (evt_s)
  );

  assign evt_hit = evt_s ^ evt_seen;

  // upper compare bytes wait here until a low-byte write sends them
  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      stage_hi <= RESET_CMP[CNT_W-1:8];
    end else if (reg_wr) begin
      for (int i = 1; i < NBYTES; i++) begin
        if (reg_addr == ADDR_W'(i)) stage_hi[i*8 +: 8] <= reg_wdata;
      end
    end
  end

  // event edge, flag, enable and wake pulse
  assign ctl_wr   = reg_wr && (reg_addr == A_CTL);
  assign flag_clr = ctl_wr && !reg_wdata[CTL_FLAG];

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      evt_seen <= 1'b0;
      flag_q   <= 1'b0;
      irq_en_q <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      evt_seen <= evt_s;
      wake_q   <= evt_hit;
      flag_q   <= evt_hit | (flag_q & ~flag_clr);
      if (ctl_wr) irq_en_q <= reg_wdata[CTL_IE];
    end
  end

  assign ctl_view = '{slow_lvl: slow_lvl, ld_ready: ld_ready,
                      flag: flag_q, irq_en: irq_en_q};

  // read path: low byte captures, upper bytes come from the capture
  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      rdata_q <= '0;
      snap_q  <= '0;
    end else if (reg_rd) begin
      rdata_q <= '0;
      if (reg_addr == A_LOW) begin
        snap_q  <= live_cnt;
        rdata_q <= live_cnt[7:0];
      end else if (reg_addr == A_CTL) begin
        rdata_q <= {4'b0000, ctl_view};
      end else begin
        for (int i = 1; i < NBYTES; i++) begin
          if (reg_addr == ADDR_W'(i)) rdata_q <= snap_q[i*8 +: 8];
        end
      end
    end
  end

  assign reg_rdata  = rdata_q;
  assign irq        = flag_q & irq_en_q;
  assign wake_pulse = wake_q;

endmodule

// File: rtl/st_timer_checker.sv
module st_timer_checker #(
  parameter int CNT_W = 24
) (
  input logic             sys_clk,
  input logic             sys_rst_n,
  input logic             slow_clk,
  input logic             slow_rst_n,
  input logic             ld_start,
  input logic             ld_ready,
  input logic             flag_q,
  input logic             flag_clr,
  input logic             evt_hit,
  input logic             wake_pulse,
  input logic [CNT_W-1:0] slow_cnt
);

  logic slow_seen;

  always_ff @(posedge slow_clk or negedge slow_rst_n) begin
    if (!slow_rst_n) slow_seen <= 1'b0;
    else             slow_seen <= 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
    slow_seen |-> (slow_cnt == CNT_W'($past(slow_cnt) + 1'b1))); // R1

  AST_LOAD_BUSY: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (ld_start && ld_ready) |=> !ld_ready); // R3

  AST_WAKE_ONE: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    wake_pulse |=> !wake_pulse); // R6

  AST_FLAG_HOLD: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (flag_q && !flag_clr) |=> flag_q); // R7

  AST_FLAG_SOURCE: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    $rose(flag_q) |-> $past(evt_hit)); // R7

  AST_EVENT_WINS: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    evt_hit |=> flag_q); // R8

endmodule

bind sleep_cmp_timer st_timer_checker #(.CNT_W(CNT_W)) u_chk (
  .sys_clk   (sys_clk),
  .sys_rst_n (sys_rst_n),
  .slow_clk  (slow_clk),
  .slow_rst_n(slow_rst_n),
  .ld_start  (ld_start),
  .ld_ready  (ld_ready),
  .flag_q    (flag_q),
  .flag_clr  (flag_clr),
  .evt_hit   (evt_hit),
  .wake_pulse(wake_pulse),
  .slow_cnt  (slow_cnt)
);

// File: tb/tb_sleep_cmp_timer.sv
`timescale 1ns/1ps
module tb_sleep_cmp_timer;

  logic       sys_clk = 1'b0;
  logic       slow_clk = 1'b0;
  logic       sys_rst_n = 1'b0;
  logic       slow_rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_rd = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq;
  logic       wake_pulse;

  int n_cmp = 0;
  int n_bad = 0;
  int model = 0;
  int wakes = 0;
  bit done = 0;

  sleep_cmp_timer dut (
    .sys_clk   (sys_clk),
    .sys_rst_n (sys_rst_n),
    .slow_clk  (slow_clk),
    .slow_rst_n(slow_rst_n),
    .reg_addr  (reg_addr),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .wake_pulse(wake_pulse)
  );

  always #2 sys_clk = ~sys_clk;
  initial begin
    #1;
    forever #32 slow_clk = ~slow_clk;
  end

  always @(posedge slow_clk) if (slow_rst_n) model <= model + 1;
  always @(negedge sys_clk) if (sys_rst_n && wake_pulse) wakes++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge sys_clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge sys_clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic wait_slow(input int n);
    repeat (n) @(posedge slow_clk);
    repeat (4) @(negedge sys_clk);
  endtask

  task automatic load_cmp(input int v);
    do_wr(2'd2, 8'((v >> 16) & 255));
    do_wr(2'd1, 8'((v >> 8) & 255));
    do_wr(2'd0, 8'(v & 255));
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int c, e;
    #10;
    chk("R10 rdata at reset", reg_rdata, 0);
    #110;
    sys_rst_n = 1'b1;
    slow_rst_n = 1'b1;
    repeat (3) @(negedge sys_clk);

    // R10 / R11 reset view of the control byte (slow level masked)
    do_rd(2'd3, v);
    chk("R10 ctl after reset", v & 8'hF7, 8'h04);
    chk("R10 irq after reset", irq, 0);

    // R10 staged upper bytes reset to 0xFF: a low-only load stays far away
    wait_slow(1);
    c = model;
    do_wr(2'd0, 8'((c + 5) & 255));
    wait_slow(10);
    do_rd(2'd3, v);
    chk("R10 no event with reset upper bytes", v[1], 0);
    chk("R10 no wake pulse", wakes, 0);

    // R11 slow clock level
    wait_slow(1);
    do_rd(2'd3, v);
    chk("R11 slow level high", v[3], 1);
    @(negedge slow_clk);
    repeat (4) @(negedge sys_clk);
    do_rd(2'd3, v);
    chk("R11 slow level low", v[3], 0);
    chk("R11 upper bits zero", v[7:4], 0);

    // R3 ready handshake
    wait_slow(1);
    c = model;
    load_cmp(c + 100000);
    do_rd(2'd3, v);
    chk("R3 ready drops", v[2], 0);
    wait_slow(1);
    do_rd(2'd3, v);
    chk("R3 still busy", v[2], 0);
    wait_slow(3);
    do_rd(2'd3, v);
    chk("R3 ready returns", v[2], 1);

    // R5 / R6 offset sweep across the load latency
    for (int k = 0; k <= 8; k++) begin
      int w0;
      wait_slow(1);
      c = model;
      w0 = wakes;
      load_cmp(c + k);
      wait_slow(12);
      do_rd(2'd3, v);
      chk($sformatf("R5 flag for offset %0d", k), v[1], (k >= 3) ? 1 : 0);
      chk($sformatf("R6 wake count for offset %0d", k), wakes - w0, (k >= 3) ? 1 : 0);
      do_wr(2'd3, 8'h00);
      do_rd(2'd3, v);
      chk("R7 clear by writing 0", v[1], 0);
    end

    // R8 / R6 clear moved across the flag-set cycle
    for (int n = 0; n <= 3; n++) begin
      int w0;
      wait_slow(1);
      c = model;
      w0 = wakes;
      load_cmp(c + 5);
      repeat (6) @(posedge slow_clk);
      repeat (n) @(negedge sys_clk);
      do_wr(2'd3, 8'h01);
      repeat (4) @(negedge sys_clk);
      do_rd(2'd3, v);
      chk($sformatf("R8 flag after clear at offset %0d", n), v[1], (n < 3) ? 1 : 0);
      chk($sformatf("R9 irq with enable, offset %0d", n), irq, (n < 3) ? 1 : 0);
      chk("R6 one wake pulse", wakes - w0, 1);
      if (n < 3) begin
        do_wr(2'd3, 8'h02);
        @(negedge sys_clk);
        chk("R9 irq gated by enable", irq, 0);
        do_rd(2'd3, v);
        chk("R7 writing 1 keeps flag", v[1], 1);
        do_wr(2'd3, 8'h03);
        @(negedge sys_clk);
        chk("R9 irq re-enabled", irq, 1);
      end
      do_wr(2'd3, 8'h00);
      @(negedge sys_clk);
      chk("R9 irq after clear", irq, 0);
    end

    // R4 low-byte write while busy is ignored
    do
      wait_slow(1);
    while ((model & 255) >= 200);
    c = model;
    load_cmp(c + 8);
    do_wr(2'd0, 8'((c + 4) & 255));
    wait_slow(6);
    do_rd(2'd3, v);
    chk("R4 busy write did not load", v[1], 0);
    wait_slow(3);
    do_rd(2'd3, v);
    chk("R4 original value fired", v[1], 1);
    do_wr(2'd3, 8'h00);

    // R1 / R2 count reads with a slow edge between low and upper reads
    for (int i = 0; i < 300; i++) begin
      logic [7:0] lo, mi, hi;
      wait_slow(1);
      e = model;
      do_rd(2'd0, lo);
      if (i % 2 == 1) wait_slow(1);
      do_rd(2'd1, mi);
      do_rd(2'd2, hi);
      chk("R1 count low byte", lo, e & 255);
      chk("R2 captured middle byte", mi, (e >> 8) & 255);
      chk("R2 captured high byte", hi, (e >> 16) & 255);
    end
    chk("R2 count passed a byte carry", (model > 256) ? 1 : 0, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule